// File: doc/BRIEF.md
# Carriage-Return Auto-Baud Generator

This block listens on an idle-high asynchronous serial line and derives the bit rate from a carriage-return character (0x0D). It does not need a divisor programmed for the system clock. It turns the measured bit period into a clock-enable pulse that repeats at a fixed oversampling multiple of the bit rate. Receivers and transmitters elsewhere on the chip can use that pulse as their sampling strobe. A flag reports once a usable rate has been acquired.

The line passes through a two-flop synchroniser, and an edge detector then drives a segment meter. The meter times the low start bit as one bit period. It then checks that the later runs of constant level match the shape of a carriage return, within a quarter of a bit. Only after the whole shape has been seen does it commit a new divisor. Each later carriage return measures the rate again, so the host can change its baud rate at any time by pressing enter. Any other character, a measurement that overflows the counter, and a rate too fast for the oversampling factor all leave the running divisor as it was.

Top module: `cr_autobaud`

## Requirements
- R1: After synchronous reset `rate_locked` is 0 and `baud_tick` stays 0 until the first accepted measurement.
- R2: A character 0x0D is sent LSB first, framed by one low start bit and one high stop bit, with bit time T clocks. It sets `rate_locked` to 1, and the divisor becomes floor(T / 2^OSR_LOG2).
- R3: While locked, `baud_tick` is high for one clock every divisor clocks, so consecutive pulses are exactly divisor cycles apart. It is never high while unlocked.
- R4: A later 0x0D sent at a different bit time replaces the divisor, and the tick spacing follows the new rate.
- R5: A character whose level runs do not follow the carriage-return shape is ignored. The shape is low T, high T, low T, high 2T, low 4T, each within plus or minus T/4. An ignored character leaves the locked state and the tick spacing unchanged.
- R6: If the measurement counter reaches its all-ones value during a character, that measurement is discarded, and the previous divisor and locked state are kept.
- R7: A measurement whose divisor would be 0 (T below 2^OSR_LOG2) is rejected and changes nothing.
- R8: Once set, `rate_locked` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_line | input | 1 | Asynchronous serial line, idle high |
| baud_tick | output | 1 | Clock-enable pulse at 2^OSR_LOG2 times the bit rate |
| rate_locked | output | 1 | High once a valid rate has been acquired |

## Verification
The assertions check on every cycle the properties that need no knowledge of the stimulus. A tick never occurs without lock, and lock never drops. Lock only rises after an accepted measurement. An accepted measurement and a counter overflow never coincide, an overflow never disturbs the stored divisor, and a locked block never holds a zero divisor. Only the bench scenarios can show the actual values. These are the tick spacing after carriage returns at several bit times, the tracking from one rate to another, and the rejection of a non-carriage-return character, an overflowing bit time and a too-fast bit time, each judged by the tick spacing seen afterwards.

// File: rtl/cr_autobaud_pkg.sv
package cr_autobaud_pkg;

  typedef enum logic {
    MTR_IDLE = 1'b0,
    MTR_RUN  = 1'b1
  } mtr_state_e;

  localparam int unsigned SEG_LAST = 4;

  // Length of segment idx of a carriage return, in bit periods.
  function automatic int unsigned seg_mult(input logic [2:0] idx);
    case (idx)
      3'd3:    return 2;
      3'd4:    return 4;
      default: return 1;
    endcase
  endfunction

  // Span len is accepted for an expected k*t when within t/4 either way.
  function automatic logic span_ok(input int unsigned len,
                                   input int unsigned t,
                                   input int unsigned k);
    int unsigned lo;
    int unsigned hi;
    lo = k * t - (t >> 2);
    hi = k * t + (t >> 2);
    return (len >= lo) && (len <= hi);
  endfunction

  // Tick divisor from a measured bit period.
  function automatic int unsigned div_of(input int unsigned t,
                                         input int unsigned osr_log2);
    return t >> osr_log2;
  endfunction

endpackage

// File: rtl/cr_autobaud_sync.sv
module cr_autobaud_sync (
  input  logic clk,
  input  logic rst,
  input  logic line_async,
  output logic line_fall,
  output logic line_rise
);
  logic s1, s2, s_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1     <= 1'b1;
      s2     <= 1'b1;
      s_prev <= 1'b1;
    end else begin
      s1     <= line_async;
      s2     <= s1;
      s_prev <= s2;
    end
  end

  assign line_fall = s_prev & ~s2;
  assign line_rise = ~s_prev & s2;
endmodule

// File: rtl/cr_autobaud_meter.sv
module cr_autobaud_meter
  import cr_autobaud_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int OSR_LOG2 = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_fall,
  input  logic             line_rise,
  output logic             meas_done,
  output logic             meas_sat,
  output logic [CNT_W-1:0] meas_div
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  mtr_state_e       st;
  logic [2:0]       seg;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] bit_t;
  logic             any_edge;
  logic             fits;
  int unsigned      cand_div;

  assign any_edge = line_fall | line_rise;
  assign fits     = span_ok(32'(cnt), 32'(bit_t), seg_mult(seg));
  assign cand_div = div_of(32'(bit_t), OSR_LOG2);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= MTR_IDLE;
      seg       <= '0;
      cnt       <= '0;
      bit_t     <= '0;
      meas_done <= 1'b0;
      meas_sat  <= 1'b0;
      meas_div  <= '0;
    end else begin
      meas_done <= 1'b0;
      meas_sat  <= 1'b0;
      case (st)
        MTR_IDLE: begin
          if (line_fall) begin
            st  <= MTR_RUN;
            seg <= '0;
            cnt <= CNT_W'(1);
          end
        end
        default: begin
          if (cnt == CNT_MAX) begin
            meas_sat <= 1'b1;
            st       <= MTR_IDLE;
          end else if (any_edge) begin
            if (seg == 3'd0) begin
              bit_t <= cnt;
              seg   <= 3'd1;
              cnt   <= CNT_W'(1);
            end else if (fits) begin
              if (seg == 3'(SEG_LAST)) begin
                st <= MTR_IDLE;
                if (cand_div != 0) begin
                  meas_done <= 1'b1;
                  meas_div  <= CNT_W'(cand_div);
                end
              end else begin
                seg <= seg + 3'd1;
                cnt <= CNT_W'(1);
              end
            end else if (line_fall) begin
              seg <= '0;
              cnt <= CNT_W'(1);
            end else begin
              st <= MTR_IDLE;
            end
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/cr_autobaud_tick.sv
module cr_autobaud_tick #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] div_in,
  input  logic             run,
  output logic             tick
);
  logic [CNT_W-1:0] div_q;
  logic [CNT_W-1:0] phase;
  logic             wrap;

  assign wrap = (phase == div_q - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      phase <= '0;
    end else if (load) begin
      div_q <= div_in;
      phase <= '0;
    end else if (run) begin
      phase <= wrap ? '0 : phase + CNT_W'(1);
    end
  end

  assign tick = run & wrap;
endmodule

// File: rtl/cr_autobaud.sv
module cr_autobaud #(
  parameter int CNT_W    = 16,
  parameter int OSR_LOG2 = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_line,
  output logic baud_tick,
  output logic rate_locked
);
  logic             line_fall;
  logic             line_rise;
  logic             meas_done;
  logic             meas_sat;
  logic [CNT_W-1:0] meas_div;

  cr_autobaud_sync u_sync (
    .clk        (clk),
    .rst        (rst),
    .line_async (rx_line),
    .line_fall  (line_fall),
    .line_rise  (line_rise)
  );

  cr_autobaud_meter #(.CNT_W(CNT_W), .OSR_LOG2(OSR_LOG2)) u_meter (
    .clk       (clk),
    .rst       (rst),
    .line_fall (line_fall),
    .line_rise (line_rise),
    .meas_done (meas_done),
    .meas_sat  (meas_sat),
    .meas_div  (meas_div)
  );

  always_ff @(posedge clk) begin
    if (rst) rate_locked <= 1'b0;
    else if (meas_done) rate_locked <= 1'b1;
  end

  cr_autobaud_tick #(.CNT_W(CNT_W)) u_tick (
    .clk    (clk),
    .rst    (rst),
    .load   (meas_done),
    .div_in (meas_div),
    .run    (rate_locked),
    .tick   (baud_tick)
  );
endmodule

// File: rtl/cr_autobaud_chk.sv
module cr_autobaud_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             baud_tick,
  input logic             rate_locked,
  input logic             meas_done,
  input logic             meas_sat,
  input logic [CNT_W-1:0] meas_div
);
  a_r3_tick_needs_lock: assert property (@(posedge clk) disable iff (rst)
    baud_tick |-> rate_locked);

  a_r8_lock_sticky: assert property (@(posedge clk) disable iff (rst)
    rate_locked |=> rate_locked);

  a_r2_lock_after_meas: assert property (@(posedge clk) disable iff (rst)
    $rose(rate_locked) |-> $past(meas_done));

  a_r6_sat_keeps_div: assert property (@(posedge clk) disable iff (rst)
    meas_sat |=> $stable(meas_div));

  a_r6_sat_not_done: assert property (@(posedge clk) disable iff (rst)
    !(meas_sat && meas_done));

  a_r7_div_nonzero: assert property (@(posedge clk) disable iff (rst)
    rate_locked |-> (meas_div != '0));
endmodule

bind cr_autobaud cr_autobaud_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .baud_tick   (baud_tick),
  .rate_locked (rate_locked),
  .meas_done   (meas_done),
  .meas_sat    (meas_sat),
  .meas_div    (meas_div)
);

// File: tb/cr_autobaud_bench.sv
module cr_autobaud_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 12;
  localparam int OSR_LOG2   = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_line = 1'b1;
  logic baud_tick;
  logic rate_locked;

  int n_checks = 0;
  int n_fail   = 0;
  int cur_div  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cr_autobaud #(.CNT_W(CNT_W), .OSR_LOG2(OSR_LOG2)) u_cr_autobaud (
    .clk         (clk),
    .rst         (rst),
    .rx_line     (rx_line),
    .baud_tick   (baud_tick),
    .rate_locked (rate_locked)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_char(input logic [7:0] ch, input int bt);
    @(negedge clk) rx_line = 1'b0;
    repeat (bt) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_line = ch[i];
      repeat (bt) @(negedge clk);
    end
    rx_line = 1'b1;
    repeat (3 * bt) @(negedge clk);
  endtask

  task automatic count_ticks(input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (baud_tick) n++;
    end
  endtask

  task automatic tick_gap(output int gap);
    int w;
    w = 0;
    while (!baud_tick && w < 4000) begin
      @(negedge clk);
      w++;
    end
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
    end while (!baud_tick && gap < 4000);
  endtask

  task automatic t_reset;
    int n;
    check(rate_locked == 1'b0, "R1 lock after reset", int'(rate_locked), 0);
    count_ticks(200, n);
    check(n == 0, "R1 ticks after reset", n, 0);
  endtask

  task automatic t_other_char_unlocked;
    int n;
    send_char(8'h55, 64);
    check(rate_locked == 1'b0, "R5 lock after non-CR", int'(rate_locked), 0);
    count_ticks(100, n);
    check(n == 0, "R5 R3 ticks while unlocked", n, 0);
  endtask

  task automatic t_cr(input int bt, input string req);
    int g;
    send_char(8'h0D, bt);
    cur_div = bt >> OSR_LOG2;
    check(rate_locked == 1'b1, {req, " locked"}, int'(rate_locked), 1);
    tick_gap(g);
    check(g == cur_div, {req, " tick gap"}, g, cur_div);
    tick_gap(g);
    check(g == cur_div, {req, " tick gap repeat"}, g, cur_div);
  endtask

  task automatic t_ignored(input logic [7:0] ch, input int bt, input string req);
    int g;
    send_char(ch, bt);
    check(rate_locked == 1'b1, {req, " lock kept R8"}, int'(rate_locked), 1);
    tick_gap(g);
    check(g == cur_div, {req, " gap kept"}, g, cur_div);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_other_char_unlocked();
    t_cr(64, "R2");
    t_cr(160, "R4");
    t_ignored(8'h55, 64, "R5");
    t_ignored(8'h0D, 1200, "R6");
    t_cr(100, "R4 second");
    t_ignored(8'h0D, 4, "R7");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule